// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block merges eight peripheral interrupt lines into one interrupt output for a CPU. A rising edge on a line latches a pending request. Each line can be masked on its own. A priority resolver picks the winning request under either a fixed order or a rotating order. The interrupt output is raised only when that winner outranks everything the CPU is already servicing.

The CPU answers with acknowledge pulses. On the first pulse the winning request moves from the pending set into the in-service set, and the controller drives bytes on `ack_data`. Two vector formats are available. In single-vector mode one pulse returns a vector number. In call mode three pulses return a three-byte subroutine call. For software that prefers polling, the same acknowledge can be taken by reading a status register. A small register port lets the CPU do the following:
- write the mask, the mode bits and the vector base;
- issue end-of-interrupt;
- read back the pending, in-service and mask sets.

Top module: `vpic_top`

## Requirements
- R1: A low-to-high transition on `irq_in[n]` sets pending bit n. Bit n stays set until it is granted. The pending set reads at address 4.
- R2: Mask bit n = 1 (address 0) removes line n from `int_out`, from acknowledge and from poll. Its pending bit still latches.
- R3: With rotation off (control bit 0 = 0), priority is fixed: line 0 is highest and line 7 is lowest.
- R4: With rotation on, an end-of-interrupt on level L makes L the lowest priority. The order then runs L+1, L+2, … (modulo 8) from highest to lowest.
- R5: `int_out` is 1 exactly when all three hold: poll mode is off, some unmasked pending request exists, and that request outranks the highest-priority in-service bit (or no bit is in service).
- R6: In single-vector mode (control bit 1 = 0), an acknowledge pulse while a winner exists does two things. It sets the winner's in-service bit and clears its pending bit. From the next clock `ack_data` = {base[7:3], level}, where base is the register at address 2.
- R7: In call mode (control bit 1 = 1), three pulses return 0xCD, then A[7:0], then A[15:8], where A = {reg3, reg2} + 8 × level. The grant happens on the first pulse.
- R8: An acknowledge with no winner reports level 7 and changes neither the pending set nor the in-service set.
- R9: A write to address 4 (end-of-interrupt) clears the highest-priority in-service bit. When nothing is in service it has no effect.
- R10: A read of address 6 returns {valid, 0000, level}, or 0x00 when there is no winner. When valid, the read grants that level the same way an acknowledge does. Poll mode (control bit 2 = 1) holds `int_out` low.
- R11: Addresses 0–3 (mask, control, base/low, high) read back what was written, reset to 0, and may be rewritten at any time. The in-service set reads at address 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, edge-detected |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for the poll side effect) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| int_out | output | 1 | Interrupt request to the CPU |
| ack_pulse | input | 1 | One-cycle acknowledge pulse from the CPU |
| ack_data | output | 8 | Vector or call byte returned for the last pulse |

## Verification
The bench sweeps every level alone and every ordered pair of levels. A resolver with a reversed or off-by-one scan returns the wrong vector number. It also sweeps every rotation bottom and drains all eight requests. A pointer updated on the wrong level, or updated in fixed mode, breaks the drain order. Nesting cases check that a lower request stays silent under a higher in-service level. They also check that a masked request neither interrupts nor gets granted, where a design that masked only `int_out` would grant it on a spurious acknowledge. Call-mode bytes are compared against the stride arithmetic for every level. Poll reads are checked for both the returned status and the grant side effect.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int NL = 8;
  localparam int LW = $clog2(NL);

  typedef logic [LW-1:0] lvl_t;
  typedef logic [NL-1:0] vec_t;

  typedef struct packed {
    logic poll;
    logic call_mode;
    logic rotate;
  } ctrl_t;

  // Single-vector number: upper bits of base, low bits are the level.
  function automatic logic [7:0] vector_num(logic [7:0] base, lvl_t lvl);
    return {base[7:LW], lvl};
  endfunction

  // Call-mode target address: base plus level times stride.
  function automatic logic [15:0] call_target(logic [15:0] base, lvl_t lvl, int unsigned stride_log2);
    return base + (16'(lvl) << stride_log2);
  endfunction

  function automatic vec_t level_bit(lvl_t lvl);
    return vec_t'(1) << lvl;
  endfunction
endpackage

// File: rtl/vpic_resolver.sv
module vpic_resolver
  import vpic_pkg::*;
(
  input  vec_t bits,
  input  lvl_t bottom,
  output logic found,
  output lvl_t level,
  output lvl_t rank
);
  vec_t rotated;

  // rotated[k] holds the line of rank k (k = 0 is highest priority)
  for (genvar k = 0; k < NL; k++) begin : g_rot
    assign rotated[k] = bits[lvl_t'(bottom + lvl_t'(k + 1))];
  end

  always_comb begin
    found = 1'b0;
    rank  = '0;
    for (int k = NL - 1; k >= 0; k--) begin
      if (rotated[k]) begin
        found = 1'b1;
        rank  = lvl_t'(k);
      end
    end
    level = lvl_t'(rank + bottom + lvl_t'(1));
  end
endmodule

// File: rtl/vpic_ackseq.sv
module vpic_ackseq
  import vpic_pkg::*;
#(
  parameter logic [7:0] CALL_OP     = 8'hCD,
  parameter int         STRIDE_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_pulse,
  input  logic       call_mode,
  input  logic       grant_ok,
  input  lvl_t       win_lvl,
  input  logic [7:0] base_lo,
  input  logic [7:0] base_hi,
  output logic       take,
  output logic [7:0] ack_data
);
  typedef enum logic [1:0] {ST_FIRST, ST_LOW, ST_HIGH} step_e;

  step_e       step_q;
  lvl_t        lvl_q;
  logic [7:0]  data_q;
  lvl_t        pick;
  logic [15:0] tgt;

  assign take     = ack_pulse && (step_q == ST_FIRST) && grant_ok;
  assign pick     = grant_ok ? win_lvl : lvl_t'(NL - 1);
  assign tgt      = call_target({base_hi, base_lo}, lvl_q, STRIDE_LOG2);
  assign ack_data = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= ST_FIRST;
      lvl_q  <= '0;
      data_q <= '0;
    end else if (ack_pulse) begin
      case (step_q)
        ST_FIRST: begin
          lvl_q <= pick;
          if (call_mode) begin
            data_q <= CALL_OP;
            step_q <= ST_LOW;
          end else begin
            data_q <= vector_num(base_lo, pick);
          end
        end
        ST_LOW: begin
          data_q <= tgt[7:0];
          step_q <= ST_HIGH;
        end
        default: begin
          data_q <= tgt[15:8];
          step_q <= ST_FIRST;
        end
      endcase
    end
  end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter logic [7:0] CALL_OP     = 8'hCD,
  parameter int         STRIDE_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       int_out,
  input  logic       ack_pulse,
  output logic [7:0] ack_data
);
  localparam logic [2:0] A_MASK = 3'd0, A_CTRL = 3'd1, A_LO = 3'd2, A_HI = 3'd3,
                         A_EOI  = 3'd4, A_ISR  = 3'd5, A_POLL = 3'd6;

  vec_t       irq_prev_q, irr_q, isr_q, mask_q;
  ctrl_t      ctrl_q;
  logic [7:0] lo_q, hi_q;
  lvl_t       bottom_q;

  // named internal events
  lvl_t eff_bottom;
  vec_t pend;
  logic req_found, isr_found, beats;
  lvl_t req_lvl, req_rank, isr_lvl, isr_rank;
  logic ack_take, poll_take, grant_fire, eoi_fire;
  vec_t grant_vec, eoi_vec, edge_vec;
  lvl_t grant_lvl;

  assign eff_bottom = ctrl_q.rotate ? bottom_q : lvl_t'(NL - 1);
  assign pend       = irr_q & ~mask_q;

  vpic_resolver u_req (.bits(pend),  .bottom(eff_bottom), .found(req_found), .level(req_lvl), .rank(req_rank));
  vpic_resolver u_isr (.bits(isr_q), .bottom(eff_bottom), .found(isr_found), .level(isr_lvl), .rank(isr_rank));

  assign beats   = req_found && (!isr_found || (req_rank < isr_rank));
  assign int_out = beats && !ctrl_q.poll;

  vpic_ackseq #(.CALL_OP(CALL_OP), .STRIDE_LOG2(STRIDE_LOG2)) u_ack (
    .clk, .rst_n, .ack_pulse,
    .call_mode(ctrl_q.call_mode),
    .grant_ok (beats),
    .win_lvl  (req_lvl),
    .base_lo  (lo_q),
    .base_hi  (hi_q),
    .take     (ack_take),
    .ack_data
  );

  assign poll_take  = bus_rd && (bus_addr == A_POLL) && beats;
  assign grant_fire = ack_take || poll_take;
  assign grant_lvl  = req_lvl;
  assign grant_vec  = grant_fire ? level_bit(grant_lvl) : '0;
  assign eoi_fire   = bus_wr && (bus_addr == A_EOI) && isr_found;
  assign eoi_vec    = eoi_fire ? level_bit(isr_lvl) : '0;
  assign edge_vec   = irq_in & ~irq_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_prev_q <= '0;
      irr_q      <= '0;
      isr_q      <= '0;
      mask_q     <= '0;
      ctrl_q     <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      bottom_q   <= lvl_t'(NL - 1);
    end else begin
      irq_prev_q <= irq_in;
      irr_q      <= (irr_q & ~grant_vec) | edge_vec;
      isr_q      <= (isr_q & ~eoi_vec) | grant_vec;
      if (eoi_fire && ctrl_q.rotate) bottom_q <= isr_lvl;
      if (bus_wr) begin
        case (bus_addr)
          A_MASK:  mask_q <= bus_wdata;
          A_CTRL:  ctrl_q <= ctrl_t'(bus_wdata[2:0]);
          A_LO:    lo_q   <= bus_wdata;
          A_HI:    hi_q   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_MASK:  bus_rdata = mask_q;
      A_CTRL:  bus_rdata = {5'b0, ctrl_q};
      A_LO:    bus_rdata = lo_q;
      A_HI:    bus_rdata = hi_q;
      A_EOI:   bus_rdata = irr_q;
      A_ISR:   bus_rdata = isr_q;
      A_POLL:  bus_rdata = beats ? {1'b1, 4'b0, req_lvl} : 8'h00;
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk
  import vpic_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic int_out,
  input logic poll,
  input vec_t mask_q,
  input vec_t irr_q,
  input vec_t isr_q,
  input logic grant_fire,
  input lvl_t grant_lvl,
  input vec_t grant_vec,
  input logic eoi_fire
);
  assert_int_needs_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr_q & ~mask_q) != '0));

  assert_all_masked_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !int_out);

  assert_poll_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    poll |-> !int_out);

  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  assert_grant_sets_isr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |=> isr_q[$past(grant_lvl)]);

  assert_eoi_one_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && !grant_fire) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

bind vpic_top vpic_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .int_out   (int_out),
  .poll      (ctrl_q.poll),
  .mask_q    (mask_q),
  .irr_q     (irr_q),
  .isr_q     (isr_q),
  .grant_fire(grant_fire),
  .grant_lvl (grant_lvl),
  .grant_vec (grant_vec),
  .eoi_fire  (eoi_fire)
);

// File: tb/test_vpic_top.sv
`timescale 1ns/100ps
module test_vpic_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       int_out;
  logic       ack_pulse = 1'b0;
  logic [7:0] ack_data;

  int n_chk = 0, n_fail = 0;

  // model state
  logic [7:0] irr_m = 0, isr_m = 0, mask_m = 0, lo_m = 0, hi_m = 0;
  logic rot_m = 0, call_m = 0, poll_m = 0;
  int bot_m = 7;

  always #2.5 clk = ~clk;

  vpic_top i_vpic_top (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int m_top(input logic [7:0] v, input int bot);
    for (int p = 0; p < 8; p++) begin
      int l = (bot + 1 + p) % 8;
      if (v[l]) return l;
    end
    return -1;
  endfunction

  function automatic int m_rank(input int l, input int bot);
    return (l - bot + 15) % 8;
  endfunction

  function automatic int m_eb();
    return rot_m ? bot_m : 7;
  endfunction

  function automatic bit m_beats();
    int r = m_top(irr_m & ~mask_m, m_eb());
    int s = m_top(isr_m, m_eb());
    return (r >= 0) && (s < 0 || m_rank(r, m_eb()) < m_rank(s, m_eb()));
  endfunction

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #0.2; d = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
    case (a)
      3'd0: mask_m = d;
      3'd1: begin rot_m = d[0]; call_m = d[1]; poll_m = d[2]; end
      3'd2: lo_m = d;
      3'd3: hi_m = d;
      3'd4: begin
        int s = m_top(isr_m, m_eb());
        if (s >= 0) begin
          isr_m[s] = 1'b0;
          if (rot_m) bot_m = s;
        end
      end
      default: ;
    endcase
  endtask

  task automatic raise(input logic [7:0] v);
    irq_in = v; tick(); irq_in = 0; tick();
    irr_m |= v;
  endtask

  task automatic state(input string tag);
    logic [7:0] d;
    chk({tag, " int_out R5"}, int_out, m_beats() && !poll_m);
    peek(3'd4, d); chk({tag, " pending R1"}, d, irr_m);
    peek(3'd5, d); chk({tag, " in-service R11"}, d, isr_m);
  endtask

  task automatic pulse();
    ack_pulse = 1; tick(); ack_pulse = 0;
  endtask

  task automatic ack(input string tag, output int lvl);
    logic [15:0] a;
    bit b = m_beats();
    lvl = b ? m_top(irr_m & ~mask_m, m_eb()) : 7;
    if (b) begin isr_m[lvl] = 1'b1; irr_m[lvl] = 1'b0; end
    if (!call_m) begin
      pulse(); chk({tag, " vector R6"}, ack_data, (lo_m & 8'hF8) | 8'(lvl));
    end else begin
      a = {hi_m, lo_m} + 16'(lvl * 8);
      pulse(); chk({tag, " opcode R7"}, ack_data, 8'hCD);
      pulse(); chk({tag, " addr low R7"}, ack_data, a[7:0]);
      pulse(); chk({tag, " addr high R7"}, ack_data, a[15:8]);
    end
    state(tag);
  endtask

  task automatic poll(input string tag);
    logic [7:0] d;
    bit b = m_beats();
    int l = m_top(irr_m & ~mask_m, m_eb());
    bus_rd = 1; bus_addr = 3'd6; #0.2; d = bus_rdata;
    chk({tag, " poll status R10"}, d, b ? (8'h80 | 8'(l)) : 8'h00);
    tick(); bus_rd = 0;
    if (b) begin isr_m[l] = 1'b1; irr_m[l] = 1'b0; end
    state(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int l;
    logic [7:0] d;
    repeat (3) tick();
    rst_n = 1; tick();

    // R11 reset state and read-back
    state("reset");
    for (int a = 0; a < 4; a++) begin
      peek(3'(a), d); chk("reset reg R11", d, 0);
    end
    wr(3'd0, 8'h5A); wr(3'd1, 8'h03); wr(3'd2, 8'hC3); wr(3'd3, 8'h7E);
    peek(3'd0, d); chk("mask readback R11", d, 8'h5A);
    peek(3'd1, d); chk("ctrl readback R11", d, 8'h03);
    peek(3'd2, d); chk("low readback R11", d, 8'hC3);
    peek(3'd3, d); chk("high readback R11", d, 8'h7E);
    wr(3'd0, 0); wr(3'd1, 0); wr(3'd2, 8'h48);

    // R1 R6: each level alone
    for (int i = 0; i < 8; i++) begin
      raise(8'(1 << i)); state("single R1");
      ack("single R6", l); chk("single level R6", 16'(l), 16'(i));
      wr(3'd4, 0); state("single eoi R9");
    end

    // R3: every ordered pair under fixed priority
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) if (a != b) begin
        raise(8'((1 << a) | (1 << b)));
        ack("pair R3", l); chk("pair winner R3", 16'(l), 16'(a < b ? a : b));
        wr(3'd4, 0);
        ack("pair second R3", l); chk("pair loser R3", 16'(l), 16'(a < b ? b : a));
        wr(3'd4, 0);
      end

    // R5 nesting
    raise(8'h20); ack("nest R5", l);
    raise(8'h40); state("nest lower R5");
    raise(8'h04); state("nest higher R5");
    ack("nest R5", l); chk("nest level R5", 16'(l), 2);
    wr(3'd4, 0); state("nest eoi R9");
    wr(3'd4, 0); state("nest eoi2 R9");
    ack("nest tail R5", l); wr(3'd4, 0);
    wr(3'd4, 0); state("eoi empty R9");

    // R2 R8: masked line is silent and spurious ack changes nothing
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, 8'(1 << i)); raise(8'(1 << i)); state("masked R2");
      ack("spurious R8", l); chk("spurious level R8", 16'(l), 7);
      wr(3'd0, 0); ack("unmasked R2", l); chk("unmasked level R2", 16'(l), 16'(i));
      wr(3'd4, 0);
    end

    // R4: rotation from every bottom, draining all eight
    wr(3'd1, 8'h01);
    for (int L = 0; L < 8; L++) begin
      raise(8'(1 << L)); ack("rot setup R4", l); wr(3'd4, 0);
      raise(8'hFF);
      for (int k = 1; k <= 8; k++) begin
        ack("rot drain R4", l); chk("rot order R4", 16'(l), 16'((L + k) % 8));
        wr(3'd4, 0);
      end
    end

    // R7: call mode for every level plus a spurious call
    wr(3'd1, 8'h02); wr(3'd2, 8'hF4); wr(3'd3, 8'h12);
    for (int i = 0; i < 8; i++) begin
      raise(8'(1 << i)); ack("call R7", l); wr(3'd4, 0);
    end
    ack("call spurious R8", l);

    // R10: poll mode
    wr(3'd1, 8'h04);
    raise(8'h48); state("poll quiet R10");
    poll("poll first R10");
    poll("poll blocked R10");
    wr(3'd4, 0); poll("poll second R10");
    wr(3'd4, 0); poll("poll empty R10");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule